// File: doc/BRIEF.md
# Static-Hint Branch Resolution Unit

This unit accepts one decoded branch per cycle and tells instruction fetch where to go next. The direction of a conditional branch is guessed from a hint bit that the compiler placed in the instruction. Fetch then follows the guessed stream until the branch can be checked against the condition register. Targets come from the unit's own adder, for program-counter-relative branches, or from one of two dedicated registers: the link register and the count register. Branches that call a subroutine write their return address into the link register as they issue.

The unit owns the link, count and condition registers. A general-purpose move port copies values into and out of them. Condition-producing units write the condition register through a separate port, and hold a busy flag while a result is still on its way. If the busy flag is low when a conditional branch arrives, the branch is checked at once. Otherwise the unit holds that one branch and stops accepting new ones until the flag drops. If the guess was wrong, a single-cycle mispredict pulse is raised together with the correct fetch address.

Top module: `brx_unit`

## Requirements
- R1: While reset is active and in the first cycle after it, the unit drives `redir_valid`, `res_valid` and `mispredict` low and `br_ready` high. The link, count and condition registers read as zero.
- R2: For `br_kind` 0 (relative) the target is `br_pc + br_disp` with bits [1:0] cleared. `redir_valid` is high in the cycle after the branch is accepted.
- R3: For `br_kind` 1 the target is the link register value held before this branch issues, with bits [1:0] cleared.
- R4: For `br_kind` 2 the target is the count register value with bits [1:0] cleared. `br_kind` 3 behaves like kind 0.
- R5: An unconditional branch (`br_cond`=0) is predicted taken. A conditional branch is predicted taken exactly when `br_hint`=1. `redir_addr` is the target when the prediction is taken and `br_pc+4` when it is not, and `redir_taken` shows the prediction.
- R6: When a branch with `br_link`=1 is accepted, the link register becomes `br_pc+4` on that clock edge. This write wins over a move to the link register in the same cycle.
- R7: A move with `mv_we`=1 writes `mv_data` to the register chosen by `mv_sel`: 0 is the link register, 1 the count register, 2 the condition register, and 3 is ignored. `rd_data` shows the register chosen by `rd_sel`, using the same codes, with 3 reading as zero.
- R8: A conditional branch accepted while `cr_busy`=0 resolves in the next cycle. It is resolved taken when condition bit `br_crsel` (bit 0 is the LSB) equals `br_sense`. A condition write in the same cycle is used.
- R9: A conditional branch accepted while `cr_busy`=1 is held. `br_ready` stays low and `res_valid` stays low until a cycle with `cr_busy`=0. The branch resolves in the cycle after that one, using the condition value of that cycle, including any write made in that cycle.
- R10: When the resolved direction differs from the prediction, `mispredict` is high for exactly one cycle, together with `res_valid`. `fix_addr` then holds the target if the branch was taken and `br_pc+4` if not. A correct prediction leaves `mispredict` low.
- R11: An unconditional branch resolves taken in the cycle after it is accepted and never mispredicts.
- R12: A condition write (`cr_we`) takes priority over a move to the condition register in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| br_valid | input | 1 | Decoded branch present |
| br_kind | input | 2 | 0 relative, 1 via link register, 2 via count register, 3 as relative |
| br_cond | input | 1 | Branch is conditional |
| br_hint | input | 1 | Static guess: taken |
| br_link | input | 1 | Save the return address in the link register |
| br_pc | input | 32 | Address of the branch |
| br_disp | input | 32 | Sign-extended displacement |
| br_crsel | input | 5 | Condition bit index |
| br_sense | input | 1 | Bit value that means taken |
| br_ready | output | 1 | Unit can accept a branch |
| cr_busy | input | 1 | Condition register result still pending |
| cr_we | input | 1 | Condition register write |
| cr_wdata | input | 32 | Condition register write value |
| mv_we | input | 1 | Move into a special register |
| mv_sel | input | 2 | Move destination |
| mv_data | input | 32 | Move value |
| rd_sel | input | 2 | Special register to read |
| rd_data | output | 32 | Read value |
| redir_valid | output | 1 | Fetch redirect present |
| redir_addr | output | 32 | Predicted fetch address |
| redir_taken | output | 1 | Prediction |
| res_valid | output | 1 | Branch resolved |
| res_taken | output | 1 | Resolved direction |
| mispredict | output | 1 | Prediction was wrong |
| fix_addr | output | 32 | Correct fetch address |

## Verification
The assertions assume that `br_valid` is raised only while `br_ready` is high, so a branch is never offered while another one is held. They also assume that `cr_busy` reflects the state of the condition register without glitching. The stimulus waits on `br_ready` before every branch. It raises and lowers `cr_busy` only around held branches, and places condition writes both before and inside the release cycle. The bench's behavioural model therefore checks both lookahead resolution and delayed resolution against the same rules.

// File: rtl/brx_pkg.sv
// Package: shared encodings for the branch resolution unit.
// Assumes: nothing; it holds only types.
package brx_pkg;
    typedef enum logic [1:0] {
        BK_REL = 2'd0,
        BK_LR  = 2'd1,
        BK_CTR = 2'd2,
        BK_RSV = 2'd3
    } br_kind_e;

    typedef enum logic [1:0] {
        SR_LR   = 2'd0,
        SR_CTR  = 2'd1,
        SR_CR   = 2'd2,
        SR_NONE = 2'd3
    } spr_sel_e;
endpackage

// File: rtl/brx_target.sv
// Target adder and return address generator.
// Assumes: br_disp is already sign-extended to AW bits; the low ALN bits of
// every target are cleared, and the return address is the branch address plus 4.
module brx_target
    import brx_pkg::*;
#(
    parameter int AW  = 32,
    parameter int ALN = 2
) (
    input  logic [1:0]    kind,
    input  logic [AW-1:0] pc,
    input  logic [AW-1:0] disp,
    input  logic [AW-1:0] lr,
    input  logic [AW-1:0] ctr,
    output logic [AW-1:0] tgt,
    output logic [AW-1:0] ret
);
    localparam logic [AW-1:0] STEP = AW'(4);

    logic [AW-1:0] raw;

    // pick the raw target source by branch form
    always_comb begin
        unique case (br_kind_e'(kind))
            BK_LR:   raw = lr;
            BK_CTR:  raw = ctr;
            default: raw = pc + disp;
        endcase
    end

    // clear the alignment bits, if any are configured
    generate
        if (ALN == 0) begin : g_noalign
            assign tgt = raw;
        end else begin : g_align
            assign tgt = {raw[AW-1:ALN], {ALN{1'b0}}};
        end
    endgenerate

    assign ret = pc + STEP;
endmodule

// File: rtl/brx_sprfile.sv
// Link, count and condition registers with move and read paths.
// Assumes: the link write from an issuing branch outranks a move to the link
// register; a condition write outranks a move to the condition register.
module brx_sprfile
    import brx_pkg::*;
#(
    parameter int DW  = 32,
    parameter int CRW = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           link_we,
    input  logic [DW-1:0]  link_data,
    input  logic           mv_we,
    input  logic [1:0]     mv_sel,
    input  logic [DW-1:0]  mv_data,
    input  logic           cr_we,
    input  logic [CRW-1:0] cr_data,
    input  logic [1:0]     rd_sel,
    output logic [DW-1:0]  lr,
    output logic [DW-1:0]  ctr,
    output logic [CRW-1:0] cr_eff,
    output logic [DW-1:0]  rd_data
);
    logic [CRW-1:0] cr_q;

    // link register: branch link write first, then move
    always_ff @(posedge clk) begin
        if (!rst_n)                               lr <= '0;
        else if (link_we)                         lr <= link_data;
        else if (mv_we && mv_sel == SR_LR)        lr <= mv_data;
    end

    // count register: written only by moves
    always_ff @(posedge clk) begin
        if (!rst_n)                               ctr <= '0;
        else if (mv_we && mv_sel == SR_CTR)       ctr <= mv_data;
    end

    // condition register: producer write first, then move
    always_ff @(posedge clk) begin
        if (!rst_n)                               cr_q <= '0;
        else if (cr_we)                           cr_q <= cr_data;
        else if (mv_we && mv_sel == SR_CR)        cr_q <= CRW'(mv_data);
    end

    // condition value seen by resolution, forwarding a same-cycle producer write
    assign cr_eff = cr_we ? cr_data : cr_q;

    // read mux for moves to a general-purpose register
    always_comb begin
        unique case (spr_sel_e'(rd_sel))
            SR_LR:   rd_data = lr;
            SR_CTR:  rd_data = ctr;
            SR_CR:   rd_data = DW'(cr_q);
            default: rd_data = '0;
        endcase
    end

    p_link_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        link_we |=> (lr == $past(link_data)));
    p_cr_priority_r12: assert property (@(posedge clk) disable iff (!rst_n)
        cr_we |=> (cr_q == $past(cr_data)));
    p_ctr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(mv_we && mv_sel == SR_CTR) |=> $stable(ctr));
endmodule

// File: rtl/brx_resolver.sv
// Prediction, fetch redirect and resolution with a one-entry hold slot.
// Assumes: br_valid is raised only while ready is high; cr_eff already
// carries any condition write of the current cycle.
module brx_resolver #(
    parameter int AW   = 32,
    parameter int CRW  = 32,
    parameter int SELW = $clog2(CRW)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            br_valid,
    input  logic            cond,
    input  logic            hint,
    input  logic [SELW-1:0] crsel,
    input  logic            sense,
    input  logic [AW-1:0]   tgt,
    input  logic [AW-1:0]   ret,
    input  logic            cr_busy,
    input  logic [CRW-1:0]  cr_eff,
    output logic            issue,
    output logic            ready,
    output logic            redir_valid,
    output logic [AW-1:0]   redir_addr,
    output logic            redir_taken,
    output logic            res_valid,
    output logic            res_taken,
    output logic            mispredict,
    output logic [AW-1:0]   fix_addr
);
    logic            pend_q;
    logic [AW-1:0]   p_tgt, p_ret;
    logic            p_pred, p_sense;
    logic [SELW-1:0] p_sel;

    logic pred, now_uncond, now_cond, late, taken_now, taken_late;

    assign ready      = !pend_q;
    assign issue      = br_valid && ready;
    assign pred       = !cond || hint;
    assign now_uncond = issue && !cond;
    assign now_cond   = issue && cond && !cr_busy;
    assign late       = pend_q && !cr_busy;
    assign taken_now  = (cr_eff[crsel] == sense);
    assign taken_late = (cr_eff[p_sel] == p_sense);

    // fetch redirect along the predicted path
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            redir_valid <= 1'b0;
            redir_addr  <= '0;
            redir_taken <= 1'b0;
        end else begin
            redir_valid <= issue;
            if (issue) begin
                redir_addr  <= pred ? tgt : ret;
                redir_taken <= pred;
            end
        end
    end

    // hold slot for a conditional branch whose condition is not yet valid
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q  <= 1'b0;
            p_tgt   <= '0;
            p_ret   <= '0;
            p_pred  <= 1'b0;
            p_sense <= 1'b0;
            p_sel   <= '0;
        end else if (issue && cond && cr_busy) begin
            pend_q  <= 1'b1;
            p_tgt   <= tgt;
            p_ret   <= ret;
            p_pred  <= pred;
            p_sense <= sense;
            p_sel   <= crsel;
        end else if (late) begin
            pend_q  <= 1'b0;
        end
    end

    // resolution result and mispredict pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid  <= 1'b0;
            res_taken  <= 1'b0;
            mispredict <= 1'b0;
            fix_addr   <= '0;
        end else begin
            res_valid  <= now_uncond || now_cond || late;
            mispredict <= 1'b0;
            if (now_uncond) begin
                res_taken <= 1'b1;
                fix_addr  <= tgt;
            end else if (now_cond) begin
                res_taken  <= taken_now;
                mispredict <= (taken_now != pred);
                fix_addr   <= taken_now ? tgt : ret;
            end else if (late) begin
                res_taken  <= taken_late;
                mispredict <= (taken_late != p_pred);
                fix_addr   <= taken_late ? p_tgt : p_ret;
            end
        end
    end

    p_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
        br_valid |-> ready);
    p_redirect_r2: assert property (@(posedge clk) disable iff (!rst_n)
        issue |=> redir_valid);
    p_lookahead_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && cond && !cr_busy) |=> res_valid);
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && cr_busy) |=> (!res_valid && !ready));
    p_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mispredict |-> res_valid);
    p_uncond_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && !cond) |=> (res_valid && res_taken && !mispredict));
endmodule

// File: rtl/brx_unit.sv
// Top: static-hint branch resolution unit.
// Assumes: one branch is offered per cycle, and only while br_ready is high;
// cr_busy is high while a condition result is still outstanding.
module brx_unit #(
    parameter int AW  = 32,
    parameter int CRW = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   br_valid,
    input  logic [1:0]             br_kind,
    input  logic                   br_cond,
    input  logic                   br_hint,
    input  logic                   br_link,
    input  logic [AW-1:0]          br_pc,
    input  logic [AW-1:0]          br_disp,
    input  logic [$clog2(CRW)-1:0] br_crsel,
    input  logic                   br_sense,
    output logic                   br_ready,
    input  logic                   cr_busy,
    input  logic                   cr_we,
    input  logic [CRW-1:0]         cr_wdata,
    input  logic                   mv_we,
    input  logic [1:0]             mv_sel,
    input  logic [AW-1:0]          mv_data,
    input  logic [1:0]             rd_sel,
    output logic [AW-1:0]          rd_data,
    output logic                   redir_valid,
    output logic [AW-1:0]          redir_addr,
    output logic                   redir_taken,
    output logic                   res_valid,
    output logic                   res_taken,
    output logic                   mispredict,
    output logic [AW-1:0]          fix_addr
);
    localparam int SELW = $clog2(CRW);

    logic [AW-1:0]  lr, ctr, tgt, ret;
    logic [CRW-1:0] cr_eff;
    logic           issue;

    brx_target #(.AW(AW), .ALN(2)) u_tgt (
        .kind (br_kind), .pc (br_pc), .disp (br_disp),
        .lr (lr), .ctr (ctr), .tgt (tgt), .ret (ret)
    );

    brx_sprfile #(.DW(AW), .CRW(CRW)) u_spr (
        .clk (clk), .rst_n (rst_n),
        .link_we (issue && br_link), .link_data (ret),
        .mv_we (mv_we), .mv_sel (mv_sel), .mv_data (mv_data),
        .cr_we (cr_we), .cr_data (cr_wdata),
        .rd_sel (rd_sel), .lr (lr), .ctr (ctr),
        .cr_eff (cr_eff), .rd_data (rd_data)
    );

    brx_resolver #(.AW(AW), .CRW(CRW), .SELW(SELW)) u_res (
        .clk (clk), .rst_n (rst_n),
        .br_valid (br_valid), .cond (br_cond), .hint (br_hint),
        .crsel (br_crsel), .sense (br_sense),
        .tgt (tgt), .ret (ret), .cr_busy (cr_busy), .cr_eff (cr_eff),
        .issue (issue), .ready (br_ready),
        .redir_valid (redir_valid), .redir_addr (redir_addr),
        .redir_taken (redir_taken), .res_valid (res_valid),
        .res_taken (res_taken), .mispredict (mispredict),
        .fix_addr (fix_addr)
    );
endmodule

// File: tb/brx_unit_test.sv
`timescale 1ns/1ps
module brx_unit_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        br_valid, br_cond, br_hint, br_link, br_sense;
    logic [1:0]  br_kind;
    logic [31:0] br_pc, br_disp;
    logic [4:0]  br_crsel;
    logic        br_ready;
    logic        cr_busy, cr_we, mv_we;
    logic [31:0] cr_wdata, mv_data, rd_data;
    logic [1:0]  mv_sel, rd_sel;
    logic        redir_valid, redir_taken, res_valid, res_taken, mispredict;
    logic [31:0] redir_addr, fix_addr;

    int n_cmp = 0, n_bad = 0;
    string cur_req = "R1";

    always #2.5 clk = ~clk;

    brx_unit uut (
        .clk(clk), .rst_n(rst_n), .br_valid(br_valid), .br_kind(br_kind),
        .br_cond(br_cond), .br_hint(br_hint), .br_link(br_link),
        .br_pc(br_pc), .br_disp(br_disp), .br_crsel(br_crsel),
        .br_sense(br_sense), .br_ready(br_ready), .cr_busy(cr_busy),
        .cr_we(cr_we), .cr_wdata(cr_wdata), .mv_we(mv_we), .mv_sel(mv_sel),
        .mv_data(mv_data), .rd_sel(rd_sel), .rd_data(rd_data),
        .redir_valid(redir_valid), .redir_addr(redir_addr),
        .redir_taken(redir_taken), .res_valid(res_valid),
        .res_taken(res_taken), .mispredict(mispredict), .fix_addr(fix_addr)
    );

    // behavioural reference state
    logic [31:0] m_lr, m_ctr, m_cr;
    bit          m_pend, q_pred, q_sense;
    logic [31:0] q_tgt, q_ret;
    int          q_sel;
    bit          e_rv, e_rt, e_sv, e_st, e_mp;
    logic [31:0] e_ra, e_fa;

    always @(posedge clk) begin
        logic [31:0] cre, tgt, ret;
        bit iss, pr, tk;
        if (!rst_n) begin
            m_lr = 0; m_ctr = 0; m_cr = 0; m_pend = 0;
            e_rv = 0; e_rt = 0; e_sv = 0; e_st = 0; e_mp = 0; e_ra = 0; e_fa = 0;
        end else begin
            cre = cr_we ? cr_wdata : m_cr;
            iss = br_valid && !m_pend;
            case (br_kind)
                2'd1: tgt = m_lr;
                2'd2: tgt = m_ctr;
                default: tgt = br_pc + br_disp;
            endcase
            tgt[1:0] = 2'b00;
            ret = br_pc + 32'd4;
            pr  = !br_cond || br_hint;
            e_rv = iss;
            if (iss) begin e_ra = pr ? tgt : ret; e_rt = pr; end
            e_sv = 0; e_mp = 0;
            if (iss && !br_cond) begin
                e_sv = 1; e_st = 1; e_fa = tgt;
            end else if (iss && !cr_busy) begin
                tk = (cre[br_crsel] == br_sense);
                e_sv = 1; e_st = tk; e_mp = (tk != pr); e_fa = tk ? tgt : ret;
            end else if (iss) begin
                m_pend = 1; q_tgt = tgt; q_ret = ret; q_pred = pr;
                q_sense = br_sense; q_sel = br_crsel;
            end else if (m_pend && !cr_busy) begin
                tk = (cre[q_sel] == q_sense);
                e_sv = 1; e_st = tk; e_mp = (tk != q_pred);
                e_fa = tk ? q_tgt : q_ret; m_pend = 0;
            end
            if (iss && br_link) m_lr = ret;
            else if (mv_we && mv_sel == 2'd0) m_lr = mv_data;
            if (mv_we && mv_sel == 2'd1) m_ctr = mv_data;
            if (cr_we) m_cr = cr_wdata;
            else if (mv_we && mv_sel == 2'd2) m_cr = mv_data;
        end
    end

    task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
        end
    endtask

    // wait to the falling edge and compare every output against the model
    task automatic tick();
        logic [31:0] erd;
        @(negedge clk);
        case (rd_sel)
            2'd0: erd = m_lr;
            2'd1: erd = m_ctr;
            2'd2: erd = m_cr;
            default: erd = 0;
        endcase
        chk("br_ready", 32'(br_ready), 32'(!m_pend));
        chk("rd_data", rd_data, erd);
        chk("redir_valid", 32'(redir_valid), 32'(e_rv));
        if (e_rv) begin
            chk("redir_addr", redir_addr, e_ra);
            chk("redir_taken", 32'(redir_taken), 32'(e_rt));
        end
        chk("res_valid", 32'(res_valid), 32'(e_sv));
        chk("mispredict", 32'(mispredict), 32'(e_mp));
        if (e_sv) begin
            chk("res_taken", 32'(res_taken), 32'(e_st));
            chk("fix_addr", fix_addr, e_fa);
        end
    endtask

    task automatic idle();
        br_valid = 0; mv_we = 0; cr_we = 0;
    endtask

    task automatic branch(input logic [1:0] k, input bit c, input bit h, input bit l,
                          input logic [31:0] pc, input logic [31:0] d,
                          input logic [4:0] sel, input bit s);
        while (!br_ready) begin idle(); tick(); end
        br_valid = 1; br_kind = k; br_cond = c; br_hint = h; br_link = l;
        br_pc = pc; br_disp = d; br_crsel = sel; br_sense = s;
        tick();
        br_valid = 0;
    endtask

    task automatic move(input logic [1:0] sel, input logic [31:0] v);
        mv_we = 1; mv_sel = sel; mv_data = v; tick(); mv_we = 0;
    endtask

    initial begin
        #20000;
        n_bad++;
        $display("FAIL watchdog: actual running expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        rst_n = 0; br_valid = 0; br_kind = 0; br_cond = 0; br_hint = 0;
        br_link = 0; br_pc = 0; br_disp = 0; br_crsel = 0; br_sense = 0;
        cr_busy = 0; cr_we = 0; cr_wdata = 0; mv_we = 0; mv_sel = 0;
        mv_data = 0; rd_sel = 0;
        repeat (3) tick();
        rst_n = 1;
        cur_req = "R1";
        for (int i = 0; i < 4; i++) begin rd_sel = 2'(i); tick(); end
        cur_req = "R7";                                // moves and reads
        move(2'd0, 32'h0000_1000);
        move(2'd1, 32'h0000_2003);
        move(2'd3, 32'hDEAD_BEEF);                      // code 3 ignored
        for (int i = 0; i < 4; i++) begin rd_sel = 2'(i); tick(); end
        cur_req = "R2";
        branch(2'd0, 0, 0, 0, 32'h100, 32'h40, 0, 0); tick();
        branch(2'd0, 0, 0, 0, 32'h203, 32'hFFFF_FFE0, 0, 0); tick();
        cur_req = "R3";
        branch(2'd1, 0, 0, 0, 32'h300, 0, 0, 0); tick();
        cur_req = "R4";
        branch(2'd2, 0, 0, 0, 32'h300, 0, 0, 0); tick();
        branch(2'd3, 0, 0, 0, 32'h400, 32'h11, 0, 0); tick();
        cur_req = "R6"; rd_sel = 2'd0;
        mv_we = 1; mv_sel = 2'd0; mv_data = 32'h7777_0000;  // move loses to link
        branch(2'd0, 0, 0, 1, 32'h500, 32'h80, 0, 0); mv_we = 0; tick();
        branch(2'd1, 0, 0, 1, 32'h800, 0, 0, 0); tick();
        cur_req = "R12"; rd_sel = 2'd2;
        cr_we = 1; cr_wdata = 32'h0000_00F0;
        mv_we = 1; mv_sel = 2'd2; mv_data = 32'h0000_000F;
        tick(); idle(); tick();
        move(2'd2, 32'h0000_0010); tick();
        cur_req = "R8";
        branch(2'd0, 1, 1, 0, 32'h900, 32'h20, 5'd4, 1); tick();
        cur_req = "R10";
        branch(2'd0, 1, 0, 0, 32'h900, 32'h20, 5'd4, 1); tick();
        branch(2'd0, 1, 1, 0, 32'h900, 32'h20, 5'd4, 0); tick();
        cur_req = "R8";                                 // forwarded write
        cr_we = 1; cr_wdata = 32'h0;
        branch(2'd0, 1, 1, 0, 32'hA00, 32'h20, 5'd4, 1); cr_we = 0; tick();
        cur_req = "R5";
        branch(2'd0, 1, 0, 0, 32'hB00, 32'h40, 5'd0, 1); tick();
        cur_req = "R9";
        cr_busy = 1;
        branch(2'd0, 1, 1, 0, 32'hC00, 32'h100, 5'd7, 1);
        tick(); tick();
        cr_we = 1; cr_wdata = 32'h0000_0080; tick(); cr_we = 0;
        cr_busy = 0; tick(); tick();
        cur_req = "R10";
        cr_busy = 1;
        branch(2'd2, 1, 0, 0, 32'hD00, 0, 5'd3, 1);
        tick();
        cr_busy = 0; cr_we = 1; cr_wdata = 32'h0000_0008; tick(); idle();
        branch(2'd0, 1, 1, 0, 32'hE00, 32'h8, 5'd3, 0); tick();
        cur_req = "R11";
        branch(2'd0, 0, 0, 0, 32'hF00, 32'h44, 5'd3, 0);
        branch(2'd2, 0, 1, 0, 32'hF04, 0, 5'd3, 0); tick(); tick();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule